// File: doc/BRIEF.md
# Dual-Modulus Swallow Feedback Divider

This block divides the output of an external dual-modulus prescaler so that a synthesizer's feedback path runs at the VCO frequency divided by N = B·P + A. It runs on the prescaler's output clock. A 12-bit main count B sets how many prescaler cycles make up one output period. A 6-bit swallow count A sets how many of those cycles the prescaler spends in its P+1 modulus. The modulus-control output tells the prescaler which modulus to use. The divided output gives a single-cycle pulse once per period.

A programming word holds A, B and a two-bit prescaler selection code. It is written through a load strobe, checked, and kept in a shadow register. The running counters pick up the shadow word only at a period boundary, or at once while the loop is held. A counter-reset input and a power-down input both hold the counters in their load state, quieten both outputs, and raise a hold flag. The reference counter and the charge pump use that flag to stop together with this divider. On release the first period starts from the load state, so it lines up with the reference counter that was released on the same edge.

Top module: `swallow_ndiv`

## Requirements
- R1: In synchronous reset, and in the first cycle after it, `hold_o` is 1, `mod_ctl` and `div_out` are 0 and `presc_sel` is 0. The default word is A=0, B=3, code 0.
- R2: When `ld_en` is high at a clock edge, `{sel_in, b_in, a_in}` enters the shadow register. While the loop is running, the counters and `presc_sel` take the new word only at the next period boundary. While the loop is held, they take it on the following edge.
- R3: In each output period, `mod_ctl` is 1 for exactly the first A prescaler cycles and 0 for the rest.
- R4: `div_out` is a one-cycle pulse in the last cycle of each period, and a period lasts exactly B prescaler cycles.
- R5: `presc_sel` codes 0, 1, 2 and 3 stand for prescaler ratios P of 8, 16, 32 and 64. Weighting each period's cycles by P+1 or P through `mod_ctl` gives B·P + A input cycles.
- R6: A word with B < 3 or B < A is dropped as a whole, and the previous word stays in force. This includes its selection code.
- R7: If `cnt_rst` or `pwr_dn` is high at an edge, `hold_o` is 1 in the following cycle and the counters reload. While `hold_o` is 1, `mod_ctl` and `div_out` stay 0.
- R8: After the hold is released, the first cycle with `hold_o` low is cycle 1 of a full period. `mod_ctl` there is 1 if A > 0, and the first `div_out` comes in cycle B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Strobe that writes the programming word |
| a_in | input | 6 | Swallow count A |
| b_in | input | 12 | Main count B |
| sel_in | input | 2 | Prescaler selection code |
| cnt_rst | input | 1 | Counter reset: hold in load state |
| pwr_dn | input | 1 | Power-down: hold in load state |
| mod_ctl | output | 1 | 1 selects P+1 in the prescaler, 0 selects P |
| div_out | output | 1 | Divided output pulse |
| presc_sel | output | 2 | Active prescaler selection code |
| hold_o | output | 1 | Loop held: reference counter reset and charge pump high-impedance |

## Verification
Some properties are checked on every cycle: the outputs stay quiet while held, the hold flag follows its two inputs, pulses last one cycle, and no modulus rise or selection change happens away from a period boundary or a hold. Other behaviour needs whole scenarios and a scoreboard of expected periods. That covers period length, swallow count, the weighted input total for each prescaler ratio, word rejection, deferred word changes, and aligned resumption after power-down.

// File: rtl/nd_pkg.sv
package nd_pkg;
    localparam int A_W   = 6;
    localparam int B_W   = 12;
    localparam int SEL_W = 2;

    typedef logic [A_W-1:0]   a_t;
    typedef logic [B_W-1:0]   b_t;
    typedef logic [SEL_W-1:0] sel_t;

    // programming word as written and as held in the shadow register
    typedef struct packed {
        sel_t sel;
        b_t   b;
        a_t   a;
    } nword_t;

    // running counter state
    typedef struct packed {
        sel_t sel;
        b_t   b;
        a_t   a;
    } nstate_t;

    function automatic logic word_ok(nword_t w, int unsigned bmin);
        return (32'(w.b) >= bmin) && (w.b >= B_W'(w.a));
    endfunction
endpackage

// File: rtl/nd_word_latch.sv
module nd_word_latch
    import nd_pkg::*;
#(
    parameter int unsigned B_MIN    = 3,
    parameter nword_t      RST_WORD = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ld_en,
    input  nword_t wr_word,
    output nword_t word_q
);
    always_ff @(posedge clk) begin
        if (rst)
            word_q <= RST_WORD;
        else if (ld_en && word_ok(wr_word, B_MIN))
            word_q <= wr_word;
    end
endmodule

// File: rtl/nd_hold_ctl.sv
module nd_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cnt_rst,
    input  logic pwr_dn,
    output logic hold_req,
    output logic held_q
);
    assign hold_req = cnt_rst | pwr_dn;

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b1;
        else     held_q <= hold_req;
    end
endmodule

// File: rtl/nd_swallow_core.sv
module nd_swallow_core
    import nd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    reload_req,
    input  nword_t  word,
    output nstate_t st,
    output logic    term
);
    assign term = (st.b == B_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (reload_req || term) begin
            st.a   <= word.a;
            st.b   <= word.b;
            st.sel <= word.sel;
        end else begin
            st.b <= st.b - B_W'(1);
            if (st.a != '0)
                st.a <= st.a - A_W'(1);
        end
    end
endmodule

// File: rtl/swallow_ndiv.sv
module swallow_ndiv
    import nd_pkg::*;
#(
    parameter int unsigned B_MIN   = 3,
    parameter int unsigned A_RST   = 0,
    parameter int unsigned B_RST   = 3,
    parameter int unsigned SEL_RST = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             cnt_rst,
    input  logic             pwr_dn,
    output logic             mod_ctl,
    output logic             div_out,
    output logic [SEL_W-1:0] presc_sel,
    output logic             hold_o
);
    localparam nword_t RST_WORD = '{sel: SEL_W'(SEL_RST), b: B_W'(B_RST), a: A_W'(A_RST)};

    nword_t  wr_word;
    nword_t  word_q;
    nstate_t st;
    logic    term;
    logic    hold_req;
    logic    held_q;

    assign wr_word = '{sel: sel_in, b: b_in, a: a_in};

    nd_word_latch #(.B_MIN(B_MIN), .RST_WORD(RST_WORD)) u_latch (
        .clk(clk), .rst(rst), .ld_en(ld_en), .wr_word(wr_word), .word_q(word_q)
    );

    nd_hold_ctl u_hold (
        .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
        .hold_req(hold_req), .held_q(held_q)
    );

    nd_swallow_core u_core (
        .clk(clk), .rst(rst), .reload_req(hold_req | held_q),
        .word(word_q), .st(st), .term(term)
    );

    assign mod_ctl   = !held_q && (st.a != '0);
    assign div_out   = !held_q && term;
    assign presc_sel = st.sel;
    assign hold_o    = held_q;
endmodule

// File: rtl/swallow_ndiv_chk.sv
module swallow_ndiv_chk (
    input logic       clk,
    input logic       rst,
    input logic       ld_en,
    input logic       cnt_rst,
    input logic       pwr_dn,
    input logic       mod_ctl,
    input logic       div_out,
    input logic [1:0] presc_sel,
    input logic       hold_o
);
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (!mod_ctl && !div_out));

    p_hold_follow_r7: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_rst || pwr_dn) |-> hold_o);

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    p_mod_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctl) |-> ($past(div_out) || $past(hold_o)));

    p_sel_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(presc_sel) |-> ($past(div_out) || $past(hold_o) || hold_o));

    p_resume_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> !div_out);
endmodule

bind swallow_ndiv swallow_ndiv_chk u_chk (
    .clk(clk), .rst(rst), .ld_en(ld_en), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
    .mod_ctl(mod_ctl), .div_out(div_out), .presc_sel(presc_sel), .hold_o(hold_o)
);

// File: tb/sim_swallow_ndiv.sv
module sim_swallow_ndiv;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    typedef struct {
        int a;
        int b;
        int p;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [5:0]  a_in = '0;
    logic [11:0] b_in = '0;
    logic [1:0]  sel_in = '0;
    logic        cnt_rst = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        mod_ctl, div_out, hold_o;
    logic [1:0]  presc_sel;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    int per_len = 0, per_mod = 0, per_sum = 0;

    swallow_ndiv u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .a_in(a_in), .b_in(b_in),
        .sel_in(sel_in), .cnt_rst(cnt_rst), .pwr_dn(pwr_dn),
        .mod_ctl(mod_ctl), .div_out(div_out), .presc_sel(presc_sel), .hold_o(hold_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int p_of(int s);
        case (s)
            0: return 8;
            1: return 16;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: measures each period and compares with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_o) begin
                per_len = 0; per_mod = 0; per_sum = 0;
            end else begin
                per_len++;
                per_mod += int'(mod_ctl);
                per_sum += mod_ctl ? p_of(int'(presc_sel)) + 1 : p_of(int'(presc_sel));
                if (div_out) begin
                    if (q.size() == 0) begin
                        chk(0, "R4", "unexpected pulse, period", per_len, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(per_len == e.b, "R4", "period length", per_len, e.b);
                        chk(per_mod == e.a, "R3", "swallow cycles", per_mod, e.a);
                        chk(per_sum == e.b * e.p + e.a, "R5", "input cycles", per_sum, e.b * e.p + e.a);
                    end
                    per_len = 0; per_mod = 0; per_sum = 0;
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic load_word(int a, int b, int s);
        ld_en = 1'b1; a_in = 6'(a); b_in = 12'(b); sel_in = 2'(s);
        step(1);
        ld_en = 1'b0;
    endtask

    task automatic push(int a, int b, int s, int n);
        for (int i = 0; i < n; i++) q.push_back('{a: a, b: b, p: p_of(s)});
    endtask

    task automatic wait_q(int left);
        int guard = 0;
        while (q.size() > left && guard < 20000) begin
            step(1);
            guard++;
        end
        chk(q.size() <= left, "R4", "pending periods", q.size(), left);
    endtask

    task automatic run_cfg(int a, int b, int s, int n);
        cnt_rst = 1'b1;
        load_word(a, b, s);
        step(1);
        chk(int'(presc_sel) == s, "R2", "code applied while held", int'(presc_sel), s);
        cnt_rst = 1'b0;
        push(a, b, s, n);
        wait_q(0);
        cnt_rst = 1'b1;
        step(2);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        chk(hold_o == 1'b1, "R1", "hold in reset", int'(hold_o), 1);
        chk(mod_ctl == 1'b0 && div_out == 1'b0, "R1", "outputs in reset", int'({mod_ctl, div_out}), 0);
        chk(presc_sel == 2'd0, "R1", "code in reset", int'(presc_sel), 0);
        rst = 1'b0;
        push(0, 3, 0, 3);               // R1 default word A=0 B=3 code 0
        wait_q(0);
        cnt_rst = 1'b1;
        step(2);

        run_cfg(5, 20, 1, 3);           // R3 R4 R5 P=16
        run_cfg(0, 7, 2, 2);            // R3 no swallow, P=32
        run_cfg(63, 63, 3, 2);          // R3 A equal to B, P=64
        run_cfg(3, 3, 0, 2);            // R4 smallest B
        run_cfg(63, 4095, 3, 1);        // R4 largest counts
        run_cfg(10, 11, 0, 2);

        // R6 rejected words keep the previous one in force
        cnt_rst = 1'b1;
        load_word(1, 2, 2);
        load_word(12, 11, 1);
        step(1);
        chk(presc_sel == 2'd0, "R6", "code after rejected words", int'(presc_sel), 0);
        cnt_rst = 1'b0;
        push(10, 11, 0, 2);
        wait_q(0);
        cnt_rst = 1'b1;
        step(2);

        // R2 word written mid-period applies at the next boundary
        load_word(4, 9, 1);
        step(1);
        cnt_rst = 1'b0;
        push(4, 9, 1, 2);
        push(2, 5, 2, 2);
        wait_q(3);
        step(2);
        load_word(2, 5, 2);
        chk(presc_sel == 2'd1, "R2", "code kept mid-period", int'(presc_sel), 1);
        wait_q(0);
        cnt_rst = 1'b1;
        step(2);

        // R7 power-down mid-period, R8 aligned resume
        load_word(5, 20, 1);
        step(1);
        cnt_rst = 1'b0;
        step(6);
        pwr_dn = 1'b1;
        step(1);
        chk(hold_o == 1'b1, "R7", "hold after power-down", int'(hold_o), 1);
        chk(mod_ctl == 1'b0, "R7", "modulus while held", int'(mod_ctl), 0);
        begin
            int seen = 0;
            for (int i = 0; i < 30; i++) begin
                seen += int'(div_out) + int'(mod_ctl);
                step(1);
            end
            chk(seen == 0, "R7", "activity while powered down", seen, 0);
        end
        pwr_dn = 1'b0;
        push(5, 20, 1, 2);
        step(1);
        chk(hold_o == 1'b0 && mod_ctl == 1'b1, "R8", "first cycle after release",
            int'({hold_o, mod_ctl}), 1);
        wait_q(0);

        done = 1;
        summary();
        $finish;
    end
endmodule